// File: doc/BRIEF.md
# Pulse Skipping Switch Controller

This block drives the power switch of a step-down converter by pulse skipping. A free-running divider turns the system clock into a reference pulse train whose period and high-phase length are fixed during each switching cycle. A registered output-voltage sample is compared with a reference word, and that comparison decides whether the reference pulse reaches the switch. The pulse is never shortened or widened to regulate. Each pulse is either passed whole or dropped whole. The only exception is a pulse whose admission comes late within the high phase, as described in R5.

The gate is held by a set/reset latch. The latch is set while the compare and the reference pulse are both true, and it is cleared when the reference pulse ends. Over a programmable window of switching cycles, the block counts the cycles in which the gate was driven and the cycles that were skipped. At the end of each window it presents both totals with a one-clock strobe, so that downstream logic can form the modulation factor skipped/(applied+skipped).

Top module: `psk_switch_ctrl`

## Requirements
- R1: While `rst_n` is low and afterwards until the block runs, `gate_out`, `applied_cnt`, `skipped_cnt` and `stats_valid` are all low.
- R2: A switching cycle lasts `period_cfg` clocks, and values below 2 count as 2. The reference pulse is high for the first `high_cfg` clocks of the cycle. Both settings are taken only at a cycle boundary or while the block is idle. With default parameters, the reset period is 1250 clocks (40 kHz from 50 MHz). When the compare holds for the whole cycle, `gate_out` is high for exactly `high_cfg` clocks, with one clock of latency.
- R3: `v_sample` is registered once per clock. The compare is true only when `v_ref` is strictly greater than the registered sample. A sample equal to or above the reference lets no pulse through.
- R4: Once the gate is set, it stays high until the reference pulse falls, even if the compare drops in the meantime.
- R5: If the compare becomes true partway through the high phase, the gate rises late and still falls at the normal point. If the compare becomes true only after the high phase, the cycle is skipped.
- R6: `gate_out` is never high in a clock that does not follow a clock with the reference pulse high, so it never exceeds `high_cfg` clocks per cycle.
- R7: A `high_cfg` of zero, or one not smaller than the period, keeps `gate_out` low, and every cycle counts as skipped.
- R8: A cycle counts as applied if the gate was set at any time during it. Otherwise it counts as skipped.
- R9: After every `window_cfg` cycles (zero counts as one), the two totals appear on `applied_cnt`/`skipped_cnt` and `stats_valid` pulses for one clock. The two totals sum to the window length, and the internal counters restart from zero. A new window length takes effect at the next window start.
- R10: When `enable` is low or `sync_clr` is high, `gate_out` goes low on the next clock, the reported totals and the internal counters read zero, and the divider restarts at the beginning of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Active-high run enable |
| sync_clr | input | 1 | Synchronous clear, forces idle |
| period_cfg | input | DIV_W | Switching period in clocks |
| high_cfg | input | DIV_W | Reference pulse high length in clocks |
| window_cfg | input | CW | Measurement window in switching cycles |
| v_sample | input | VW | Unsigned output-voltage sample |
| v_ref | input | VW | Unsigned reference word |
| gate_out | output | 1 | Switch gate drive |
| applied_cnt | output | CW | Applied cycles in the last window |
| skipped_cnt | output | CW | Skipped cycles in the last window |
| stats_valid | output | 1 | One-clock strobe when new totals are shown |

## Verification
The embedded assertions check the following on every clock:
- the gate only follows a high reference pulse;
- the gate only starts after a true compare;
- the gate holds once set while the pulse lasts;
- the gate is off whenever the block is idle;
- the divider stays inside its period;
- each window's totals add up to the window length.

Other behaviours need the bench's timed scenarios, which line stimulus up with the cycle count:
- the exact pulse width;
- the shortened late-start pulse and the late rise that skips the cycle;
- the equality case of the compare;
- the effect of a zero or oversized high length;
- the reloading of settings at cycle boundaries;
- the zeroed totals after a disable or a clear.

// File: rtl/psk_pkg.sv
package psk_pkg;

  // Per-cycle outcome handed from the gate latch to the statistics counters.
  typedef struct packed {
    logic done;     // last clock of the switching cycle
    logic applied;  // gate was set at some point in this cycle
  } psk_cycle_t;

  // Divider ratio for the requested switching frequency.
  function automatic int unsigned div_ratio(int unsigned clk_hz, int unsigned sw_hz);
    return clk_hz / sw_hz;
  endfunction

endpackage

// File: rtl/psk_pulse_gen.sv
module psk_pulse_gen #(
  parameter int DIV_W      = 16,
  parameter int DEF_PERIOD = 1250,
  parameter int DEF_HIGH   = 625
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] period_cfg,
  input  logic [DIV_W-1:0] high_cfg,
  output logic             ref_pulse,
  output logic             cycle_end
);

  localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);
  localparam logic [DIV_W-1:0] MIN_PER = DIV_W'(2);
  localparam logic [DIV_W-1:0] RST_PER = DIV_W'(DEF_PERIOD);
  localparam logic [DIV_W-1:0] RST_HI  = DIV_W'(DEF_HIGH);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] per_q, per_d;
  logic [DIV_W-1:0] hi_q, hi_d;
  logic [DIV_W-1:0] per_in;
  logic             load;

  // Next-state logic: shadow settings reload only at a boundary or while idle.
  always_comb begin
    per_in    = (period_cfg < MIN_PER) ? MIN_PER : period_cfg;
    cycle_end = run && (cnt_q == (per_q - ONE));
    ref_pulse = run && (hi_q < per_q) && (cnt_q < hi_q);
    load      = !run || cycle_end;
    cnt_d     = load ? '0 : (cnt_q + ONE);
    per_d     = load ? per_in : per_q;
    hi_d      = load ? high_cfg : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= RST_PER;
      hi_q  <= RST_HI;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      hi_q  <= hi_d;
    end
  end

  // R2: the phase counter never leaves the current period.
  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < per_q))
    else $error("phase counter outside period");

endmodule

// File: rtl/psk_gate_latch.sv
module psk_gate_latch
  import psk_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ref_pulse,
  input  logic          cycle_end,
  input  logic [VW-1:0] v_sample,
  input  logic [VW-1:0] v_ref,
  output logic          gate,
  output psk_cycle_t    cyc
);

  logic [VW-1:0] vs_q;
  logic          gate_q, gate_d;
  logic          seen_q, seen_d;
  logic          cmp;
  logic          smp_en;

  // Next-state logic: set while pulse and compare agree, clear when pulse ends.
  always_comb begin
    smp_en      = 1'b1;
    cmp         = (v_ref > vs_q);
    gate_d      = run && ref_pulse && (gate_q || cmp);
    seen_d      = (cycle_end || !run) ? 1'b0 : (seen_q || gate_d);
    cyc.done    = cycle_end;
    cyc.applied = seen_q || gate_d;
    gate        = gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q   <= '0;
      gate_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (smp_en) vs_q <= v_sample;
      gate_q <= gate_d;
      seen_q <= seen_d;
    end
  end

  // R6: gate only follows a clock with the reference pulse high.
  assert_gate_in_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> $past(ref_pulse))
    else $error("gate outside reference pulse");

  // R3: a new pulse starts only after a true compare.
  assert_start_needs_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(cmp))
    else $error("gate started without compare");

  // R4: once set, the gate holds while the pulse lasts.
  assert_hold_until_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && ref_pulse && run) |=> gate_q)
    else $error("gate dropped before pulse end");

  // R10: idle forces the gate low.
  assert_idle_gate_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !gate_q)
    else $error("gate high while idle");

endmodule

// File: rtl/psk_stats.sv
module psk_stats
  import psk_pkg::*;
#(
  parameter int CW         = 16,
  parameter int DEF_WINDOW = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  psk_cycle_t    cyc,
  input  logic [CW-1:0] window_cfg,
  output logic [CW-1:0] applied_cnt,
  output logic [CW-1:0] skipped_cnt,
  output logic          stats_valid
);

  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] RST_WIN = CW'(DEF_WINDOW);

  logic [CW-1:0] p_q, p_d, s_q, s_d, pos_q, pos_d, win_q, win_d;
  logic [CW-1:0] ap_q, ap_d, sk_q, sk_d;
  logic          vld_q, vld_d;
  logic [CW-1:0] win_in, inc_p, inc_s;
  logic          last;

  always_comb begin
    win_in = (window_cfg == '0) ? ONE : window_cfg;
    inc_p  = {{(CW-1){1'b0}}, cyc.applied};
    inc_s  = {{(CW-1){1'b0}}, ~cyc.applied};
    last   = cyc.done && (pos_q == (win_q - ONE));
    p_d    = p_q;
    s_d    = s_q;
    pos_d  = pos_q;
    win_d  = win_q;
    ap_d   = ap_q;
    sk_d   = sk_q;
    vld_d  = 1'b0;
    if (!run) begin
      p_d   = '0;
      s_d   = '0;
      pos_d = '0;
      ap_d  = '0;
      sk_d  = '0;
      win_d = win_in;
    end else if (cyc.done) begin
      if (last) begin
        ap_d  = p_q + inc_p;
        sk_d  = s_q + inc_s;
        p_d   = '0;
        s_d   = '0;
        pos_d = '0;
        win_d = win_in;
        vld_d = 1'b1;
      end else begin
        p_d   = p_q + inc_p;
        s_d   = s_q + inc_s;
        pos_d = pos_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q   <= '0;
      s_q   <= '0;
      pos_q <= '0;
      win_q <= RST_WIN;
      ap_q  <= '0;
      sk_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      p_q   <= p_d;
      s_q   <= s_d;
      pos_q <= pos_d;
      win_q <= win_d;
      ap_q  <= ap_d;
      sk_q  <= sk_d;
      vld_q <= vld_d;
    end
  end

  assign applied_cnt = ap_q;
  assign skipped_cnt = sk_q;
  assign stats_valid = vld_q;

  // R9: reported totals cover exactly the closed window.
  assert_window_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (({1'b0, ap_q} + {1'b0, sk_q}) == {1'b0, $past(win_q)}))
    else $error("window totals do not match window length");

  // R9: the strobe lasts one clock.
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q)
    else $error("stats strobe longer than one clock");

endmodule

// File: rtl/psk_switch_ctrl.sv
module psk_switch_ctrl
  import psk_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SW_HZ      = 40_000,
  parameter int DIV_W      = 16,
  parameter int VW         = 12,
  parameter int CW         = 16,
  parameter int DEF_WINDOW = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_clr,
  input  logic [DIV_W-1:0] period_cfg,
  input  logic [DIV_W-1:0] high_cfg,
  input  logic [CW-1:0]    window_cfg,
  input  logic [VW-1:0]    v_sample,
  input  logic [VW-1:0]    v_ref,
  output logic             gate_out,
  output logic [CW-1:0]    applied_cnt,
  output logic [CW-1:0]    skipped_cnt,
  output logic             stats_valid
);

  localparam int DEF_PERIOD = int'(div_ratio(CLK_HZ, SW_HZ));
  localparam int DEF_HIGH   = DEF_PERIOD / 2;

  logic       run;
  logic       ref_pulse;
  logic       cycle_end;
  psk_cycle_t cyc;

  assign run = enable && !sync_clr;

  psk_pulse_gen #(
    .DIV_W     (DIV_W),
    .DEF_PERIOD(DEF_PERIOD),
    .DEF_HIGH  (DEF_HIGH)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .period_cfg(period_cfg),
    .high_cfg  (high_cfg),
    .ref_pulse (ref_pulse),
    .cycle_end (cycle_end)
  );

  psk_gate_latch #(
    .VW(VW)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ref_pulse(ref_pulse),
    .cycle_end(cycle_end),
    .v_sample (v_sample),
    .v_ref    (v_ref),
    .gate     (gate_out),
    .cyc      (cyc)
  );

  psk_stats #(
    .CW        (CW),
    .DEF_WINDOW(DEF_WINDOW)
  ) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cyc        (cyc),
    .window_cfg (window_cfg),
    .applied_cnt(applied_cnt),
    .skipped_cnt(skipped_cnt),
    .stats_valid(stats_valid)
  );

endmodule

// File: tb/psk_switch_ctrl_tb.sv
`timescale 1ns/1ps
module psk_switch_ctrl_tb;

  typedef struct {
    int    p;
    int    q;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        sync_clr;
  logic [15:0] period_cfg;
  logic [15:0] high_cfg;
  logic [15:0] window_cfg;
  logic [11:0] v_sample;
  logic [11:0] v_ref;
  logic        gate_out;
  logic [15:0] applied_cnt;
  logic [15:0] skipped_cnt;
  logic        stats_valid;

  int   n_checks = 0;
  int   n_fails  = 0;
  int   rpt      = 0;
  int   per_b    = 10;
  exp_t sb[$];

  localparam logic [11:0] V_LOW  = 12'd1000;
  localparam logic [11:0] V_HIGH = 12'd3000;
  localparam logic [11:0] V_REF  = 12'd2000;

  psk_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_clr(sync_clr),
    .period_cfg(period_cfg), .high_cfg(high_cfg), .window_cfg(window_cfg),
    .v_sample(v_sample), .v_ref(v_ref), .gate_out(gate_out),
    .applied_cnt(applied_cnt), .skipped_cnt(skipped_cnt), .stats_valid(stats_valid)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected window totals as reports appear.
  always @(negedge clk) begin
    if (rst_n && stats_valid) begin
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        chk(applied_cnt == 16'(it.p), {it.tag, " applied"}, int'(applied_cnt), it.p);
        chk(skipped_cnt == 16'(it.q), {it.tag, " skipped"}, int'(skipped_cnt), it.q);
      end
      rpt++;
    end
  end

  task automatic wait_report();
    int s;
    s = rpt;
    wait (rpt != s);
  endtask

  task automatic push(input int p, input int q, input string tag);
    exp_t it;
    it.p = p; it.q = q; it.tag = tag;
    sb.push_back(it);
  endtask

  // One-cycle window mode: measure gate-high clocks of one cycle.
  task automatic measure(input int k, input logic [11:0] v_new, input int exp_hi,
                         input int exp_p, input string tag);
    int hi;
    hi = 0;
    wait_report();
    push(exp_p, 1 - exp_p, tag);
    for (int pos = 0; pos < per_b; pos++) begin
      if (pos == k) v_sample = v_new;
      if (gate_out) hi++;
      if (pos != per_b - 1) @(negedge clk);
    end
    chk(hi == exp_hi, {tag, " gate width"}, hi, exp_hi);
  endtask

  task automatic baseline(input logic [11:0] v);
    v_sample = v;
    wait_report();
  endtask

  task automatic idle_check(input string tag);
    int hi;
    hi = 0;
    v_sample = V_LOW;
    @(negedge clk);
    @(negedge clk);
    chk(applied_cnt == 0, {tag, " applied zero"}, int'(applied_cnt), 0);
    chk(skipped_cnt == 0, {tag, " skipped zero"}, int'(skipped_cnt), 0);
    for (int i = 0; i < 30; i++) begin
      if (gate_out || stats_valid) hi++;
      @(negedge clk);
    end
    chk(hi == 0, {tag, " gate/strobe low while idle"}, hi, 0);
  endtask

  initial begin
    #3_000_000;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rpt, -1);
    $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; sync_clr = 1'b0;
    period_cfg = 16'd10; high_cfg = 16'd4; window_cfg = 16'd5;
    v_sample = V_LOW; v_ref = V_REF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(gate_out == 1'b0, "R1 gate", int'(gate_out), 0);
    chk(applied_cnt == 0 && skipped_cnt == 0, "R1 counts", int'(applied_cnt) + int'(skipped_cnt), 0);
    chk(stats_valid == 1'b0, "R1 strobe", int'(stats_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(gate_out == 1'b0 && stats_valid == 1'b0, "R1 idle after reset", int'(gate_out), 0);

    // R8/R9: all cycles applied, window of 5
    enable = 1'b1;
    wait_report();
    push(5, 0, "R8 all applied");
    push(5, 0, "R9 window total");
    wait_report(); wait_report();

    // R3: sample above reference skips all
    v_sample = V_HIGH;
    wait_report();
    push(0, 5, "R3 above reference");
    wait_report();
    // R3: equal sample also skips
    v_sample = V_REF;
    wait_report();
    push(0, 5, "R3 equal skips");
    wait_report();

    // R9: window 0 acts as one cycle per report
    window_cfg = 16'd0;
    wait_report(); wait_report();

    baseline(V_LOW);  measure(-1, V_LOW, 4, 1, "R2 full width");
    baseline(V_HIGH); measure(-1, V_HIGH, 0, 0, "R8 skipped cycle");
    baseline(V_LOW);  measure(1, V_HIGH, 4, 1, "R4 hold after compare drop");
    baseline(V_HIGH); measure(1, V_LOW, 2, 1, "R5 late start");
    baseline(V_HIGH); measure(5, V_LOW, 0, 0, "R5 rise after pulse");

    // R2: new period and high length taken at a boundary
    period_cfg = 16'd12; high_cfg = 16'd6;
    baseline(V_LOW); wait_report();
    per_b = 12;
    measure(-1, V_LOW, 6, 1, "R2 reprogrammed width");

    // R7: zero and oversized high length
    high_cfg = 16'd0;
    baseline(V_LOW); wait_report();
    measure(-1, V_LOW, 0, 0, "R7 zero high");
    high_cfg = 16'd12;
    baseline(V_LOW); wait_report();
    measure(-1, V_LOW, 0, 0, "R7 high equals period");

    period_cfg = 16'd10; high_cfg = 16'd4; per_b = 10;
    wait_report(); wait_report();

    // R10: disable and synchronous clear
    enable = 1'b0;
    idle_check("R10 disable");
    window_cfg = 16'd5;
    enable = 1'b1;
    wait_report();
    push(5, 0, "R10 resume after disable");
    wait_report();
    sync_clr = 1'b1;
    idle_check("R10 sync clear");
    sync_clr = 1'b0;
    wait_report();
    push(5, 0, "R10 resume after clear");
    wait_report();
    repeat (2) @(negedge clk);

    chk(sb.size() == 0, "R9 all reports seen", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule